// File: doc/BRIEF.md
# Continuous-Mode Serial Slave Transceiver

This block is the slave end of a clocked serial link that carries 8-bit words in both directions. An external master drives the serial clock, the data line into the block and an active-low select line. The block synchronizes all three into the system clock domain. On each falling serial clock it drives one outgoing bit, most significant bit first. On each rising serial clock it samples one incoming bit. The serial clock idles high. Operation needs the mode field `clk_sel` set to 3'b111, which selects the externally supplied clock.

Software feeds outgoing words through a one-word holding buffer in front of the shift register. The block pulses `tx_irq` when it moves the held word into the shift register, so the next word can be written while the current one is still shifting. If that write comes too late, the output keeps the level of the last bit it sent while the master keeps clocking. The late word then starts on the very next falling edge, wherever the master is in its framing. Nothing moves in either direction until the buffer has been written once after `enable` rises. `busy` shows that a word is on the wire. Software lowers `enable` only after `busy` reads low, and doing so stops the block.

The transmit side is a valid/ready stream: a word is accepted on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is high only while the block is enabled and the buffer is empty, and a writer must hold the word until it is accepted. The receive side cannot apply back-pressure, because the master cannot be stalled. `rx_valid` is a one-cycle pulse that also serves as the receive-complete interrupt. `rx_data` holds the word until the next one replaces it.

Top module: `cont_slave_xcvr`

## Requirements
- R1: After `enable` rises, serial clocks are ignored until the first accepted transmit write: `sdo` stays 0 and `rx_valid` does not pulse.
- R2: Words leave MSB first. `sdo` takes a new bit after each synchronized falling serial edge, and `sdi_in` is sampled on each synchronized rising edge.
- R3: A transmit write is accepted when `tx_valid && tx_ready`, which makes `tx_ready` low. When the held word enters the shift register, `tx_irq` pulses for one cycle and `tx_ready` returns high.
- R4: A word written before the previous word's last falling edge follows it with no gap. For example, 0x55 then 0xAA reads as exactly 0x55 then 0xAA at the master.
- R5: With the buffer empty and no word shifting, falling edges leave `sdo` at the level of the last bit sent.
- R6: A word written during an underrun starts on the next falling edge, even mid-frame. After 0xAA, three held bits followed by 0x96 give the master 0x12 and then 0xC0.
- R7: After every 8 rising edges, `rx_data` takes the sampled word (first bit in MSB) and `rx_valid` pulses for one cycle. This cadence continues during an underrun.
- R8: `busy` rises when a word enters the shift register and falls on the rising edge that samples that word's last bit, unless a new word has been loaded.
- R9: While `enable` is low, `sdo` is 0, `busy` is 0, `tx_ready` is 0, the buffer is empty and the bit counters are cleared. After re-enable, a new first write is needed (R1).
- R10: Serial edges are ignored unless `clk_sel` equals 3'b111.
- R11: Serial edges are ignored while the synchronized `cs_n_in` is high.
- R12: If a write is accepted in the same cycle as a falling edge during an underrun, that edge still holds `sdo`, and the new word's MSB appears on the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low stops and clears the block |
| clk_sel | input | 3 | Clock-source field; 3'b111 selects the external serial clock |
| sclk_in | input | 1 | Serial clock from master, idles high |
| sdi_in | input | 1 | Serial data from master |
| cs_n_in | input | 1 | Active-low select from master |
| sdo | output | 1 | Serial data to master |
| tx_valid | input | 1 | Transmit word valid |
| tx_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Transmit buffer can take a word |
| rx_valid | output | 1 | One-cycle pulse: received word in `rx_data` |
| rx_data | output | 8 | Last received word |
| tx_irq | output | 1 | One-cycle pulse: buffer moved to shift register |
| busy | output | 1 | A word is being shifted |

## Verification
Two events can land in the same system cycle: a software write into the empty buffer and a synchronized falling edge during an underrun. The bench drives the serial clock low on a known clock phase and counts the two synchronizer stages. It then presents `tx_valid` so that the write is accepted on exactly the edge where the falling edge is acted on. It judges the result at the master: the bit sampled in that low phase still shows the held level, and the following seven bits carry the new word's upper bits.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_EXT_CLK = 3'b111;
  // positions in the synchronizer bundle
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_SDI  = 1;
  localparam int unsigned PIN_CSN  = 2;
  localparam int unsigned PIN_CNT  = 3;
  // idle values: clock high, data low, select deasserted
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b101;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[gi]}};
      else        chain_q <= {chain_q[STAGES-2:0], d[gi]};
    end
    assign q[gi] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cs_tx_path.sv
module cs_tx_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         active,
  input  logic         fall,
  input  logic         rise,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         sdo,
  output logic         load_pulse,
  output logic         busy,
  output logic         buf_full
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  hold_q, shift_q;
  logic [CW-1:0] left_q;
  logic          full_q, busy_q, sdo_q, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shift_q <= '0;
      left_q  <= '0;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      sdo_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!enable) begin
      left_q  <= '0;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      sdo_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_en) begin
        hold_q <= wr_data;
        full_q <= 1'b1;
      end
      if (active && fall) begin
        if (left_q != '0) begin
          sdo_q   <= shift_q[W-1];
          shift_q <= shift_q << 1;
          left_q  <= left_q - CW'(1);
        end else if (full_q) begin
          sdo_q   <= hold_q[W-1];
          shift_q <= hold_q << 1;
          left_q  <= CW'(W-1);
          full_q  <= 1'b0;
          busy_q  <= 1'b1;
          irq_q   <= 1'b1;
        end
        // otherwise underrun: sdo_q keeps the last bit
      end
      if (active && rise && left_q == '0) busy_q <= 1'b0;
    end
  end

  assign sdo        = sdo_q;
  assign load_pulse = irq_q;
  assign busy       = busy_q;
  assign buf_full   = full_q;

  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r3_irq_empties: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!full_q && busy_q));
  a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sdo_q && !busy_q && !full_q));
  a_r5_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active && fall && left_q == '0 && !full_q) |=> $stable(sdo_q));
endmodule

// File: rtl/cs_rx_path.sv
module cs_rx_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         active,
  input  logic         rise,
  input  logic         sdi,
  output logic [W-1:0] word,
  output logic         done
);
  localparam int unsigned CW = $clog2(W);

  logic [W-2:0]  shift_q;
  logic [W-1:0]  word_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (!enable) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (active && rise) begin
        shift_q <= {shift_q[W-3:0], sdi};
        if (cnt_q == CW'(W-1)) begin
          word_q <= {shift_q, sdi};
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign word = word_q;
  assign done = done_q;

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r9_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!done_q && cnt_q == '0));
endmodule

// File: rtl/cont_slave_xcvr.sv
module cont_slave_xcvr
  import cs_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              sclk_in,
  input  logic              sdi_in,
  input  logic              cs_n_in,
  output logic              sdo,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              tx_irq,
  output logic              busy
);
  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic sclk_prev_q, rise, fall, armed_q, active, tx_fire, buf_full;

  assign pins_raw[PIN_SCLK] = sclk_in;
  assign pins_raw[PIN_SDI]  = sdi_in;
  assign pins_raw[PIN_CSN]  = cs_n_in;

  cs_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= pins_s[PIN_SCLK];
  end

  assign rise = pins_s[PIN_SCLK] & ~sclk_prev_q;
  assign fall = ~pins_s[PIN_SCLK] & sclk_prev_q;

  assign tx_ready = enable & ~buf_full;
  assign tx_fire  = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (!enable) armed_q <= 1'b0;
    else if (tx_fire) armed_q <= 1'b1;
  end

  assign active = enable & armed_q & (clk_sel == SEL_EXT_CLK) & ~pins_s[PIN_CSN];

  cs_tx_path #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .active(active),
    .fall(fall), .rise(rise), .wr_en(tx_fire), .wr_data(tx_data),
    .sdo(sdo), .load_pulse(tx_irq), .busy(busy), .buf_full(buf_full)
  );

  cs_rx_path #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .active(active),
    .rise(rise), .sdi(pins_s[PIN_SDI]), .word(rx_data), .done(rx_valid)
  );

  a_r1_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (!rx_valid && !tx_irq && !busy));
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> !tx_ready);
endmodule

// File: tb/cont_slave_xcvr_tb_top.sv
module cont_slave_xcvr_tb_top;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [2:0] clk_sel = 3'b111;
  logic sclk_in = 1'b1, sdi_in = 1'b0, cs_n_in = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic sdo, tx_ready, rx_valid, tx_irq, busy;
  logic [7:0] rx_data;

  int checks = 0, errs = 0;
  int rx_seen = 0, irq_seen = 0;
  logic [7:0] rx_last = '0;

  always #5 clk = ~clk;

  cont_slave_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
    .sclk_in(sclk_in), .sdi_in(sdi_in), .cs_n_in(cs_n_in), .sdo(sdo),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_irq(tx_irq), .busy(busy)
  );

  always @(posedge clk) begin
    if (rx_valid) begin rx_seen <= rx_seen + 1; rx_last <= rx_data; end
    if (tx_irq) irq_seen <= irq_seen + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one serial bit: fall, drive sdi, sample sdo at end of low phase, rise
  task automatic sbit(input logic din, output logic got);
    @(negedge clk); sclk_in = 1'b0; sdi_in = din;
    repeat (H) @(negedge clk);
    got = sdo; sclk_in = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic sword(input logic [7:0] mosi, output logic [7:0] miso);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      sbit(mosi[i], b);
      miso[i] = b;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset sdo", sdo, 0);
    chk("R9 reset tx_ready", tx_ready, 0);
    chk("R9 reset busy", busy, 0);
    chk("R7 reset rx_valid", rx_valid, 0);
  endtask

  task automatic t_unarmed;
    logic [7:0] m;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 ready after enable", tx_ready, 1);
    sword(8'hFF, m);
    chk("R1 sdo quiet before first write", m, 8'h00);
    chk("R1 no rx before first write", rx_seen, 0);
    chk("R1 busy low before first write", busy, 0);
  endtask

  task automatic t_stream;
    logic [7:0] m;
    logic b;
    int irq0, rx0;
    irq0 = irq_seen; rx0 = rx_seen;
    wr(8'h55);
    chk("R3 ready low when full", tx_ready, 0);
    m = '0;
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] mosi;
      mosi = 8'h3C;
      sbit(mosi[i], b);
      m[i] = b;
      if (i == 7) begin
        chk("R3 irq on load", irq_seen, irq0 + 1);
        chk("R3 ready after load", tx_ready, 1);
        chk("R8 busy while shifting", busy, 1);
        wr(8'hAA);
      end
    end
    chk("R2 msb-first word", m, 8'h55);
    chk("R7 rx word", rx_last, 8'h3C);
    chk("R7 rx count", rx_seen, rx0 + 1);
    sword(8'hC3, m);
    chk("R4 back-to-back second word", m, 8'hAA);
    chk("R7 rx second word", rx_last, 8'hC3);
    chk("R8 busy low after last bit", busy, 0);
  endtask

  task automatic t_underrun;
    logic [7:0] m;
    int rx0;
    rx0 = rx_seen;
    sword(8'h5A, m);
    chk("R5 hold last bit 0", m, 8'h00);
    chk("R7 rx continues in underrun", rx_seen, rx0 + 1);
    chk("R7 rx data in underrun", rx_last, 8'h5A);
  endtask

  task automatic t_restart;
    logic [7:0] m, mosi;
    logic b;
    mosi = 8'hE7;
    m = '0;
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) wr(8'h96);
      sbit(mosi[i], b);
      m[i] = b;
    end
    chk("R6 mixed word", m, 8'h12);
    chk("R7 rx during restart", rx_last, 8'hE7);
    sword(8'h00, m);
    chk("R6 tail then hold", m, 8'hC0);
  endtask

  task automatic t_collide;
    logic [7:0] m;
    logic b;
    // fall lands in the same cycle as the write
    @(negedge clk); sclk_in = 1'b0; sdi_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hFF;
    @(negedge clk); tx_valid = 1'b0;
    repeat (H - 1) @(negedge clk);
    m[7] = sdo;
    chk("R12 write accepted", tx_ready, 0);
    sclk_in = 1'b1;
    repeat (H) @(negedge clk);
    for (int i = 6; i >= 0; i--) begin
      sbit(1'b0, b);
      m[i] = b;
    end
    chk("R12 collide edge holds then new word", m, 8'h7F);
    sword(8'h00, m);
    chk("R5 hold last bit 1", m, 8'hFF);
  endtask

  task automatic t_sel_cs;
    logic [7:0] m;
    int rx0;
    rx0 = rx_seen;
    clk_sel = 3'b000;
    sword(8'h0F, m);
    chk("R10 no rx with other clk_sel", rx_seen, rx0);
    clk_sel = 3'b111;
    cs_n_in = 1'b1;
    repeat (4) @(negedge clk);
    sword(8'hF0, m);
    chk("R11 no rx while deselected", rx_seen, rx0);
    cs_n_in = 1'b0;
    repeat (4) @(negedge clk);
    sword(8'h66, m);
    chk("R11 rx resumes when selected", rx_last, 8'h66);
  endtask

  task automatic t_disable;
    logic [7:0] m;
    int rx0;
    wr(8'h33);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 sdo low when off", sdo, 0);
    chk("R9 busy low when off", busy, 0);
    chk("R9 ready low when off", tx_ready, 0);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 buffer emptied", tx_ready, 1);
    rx0 = rx_seen;
    sword(8'hFF, m);
    chk("R9 re-arm needed sdo", m, 8'h00);
    chk("R1 re-arm needed rx", rx_seen, rx0);
    wr(8'h81);
    sword(8'h18, m);
    chk("R2 word after re-arm", m, 8'h81);
    chk("R7 rx after re-arm", rx_last, 8'h18);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unarmed();
    t_stream();
    t_underrun();
    t_restart();
    t_collide();
    t_sel_cs();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule